// File: doc/BRIEF.md
# Program-Memory Table Access Unit

This block moves bytes between the data file and program memory. It holds a 16-bit table latch and a 16-bit table pointer. The data file sees the latch one byte at a time, and program memory sees it as a full word at the address in the pointer. It decodes four instruction forms. Two latch-only forms finish in one cycle: one copies a latch byte out to a file register, the other loads a latch byte from the file. Two transfer forms use memory: a table read and a table write. Each takes at least two cycles and can advance the pointer by one once it completes.

A table read does three things in order. In its issue cycle it hands the file the selected byte of the latch as it stands. It then refills the whole latch from program memory. Last, it applies the increment. A table write first merges the file byte into the selected half of the latch. It then presents the whole latch to memory and waits for ready. An abort input ends a write that memory never acknowledges; this covers writes aimed at internal programmable memory, which end on an interrupt event. A table read whose file destination is the program-counter low byte holds the unit busy for one more cycle. While the unit is busy it accepts no new instruction. The pointer is loaded through a dedicated set port.

Top module: `tbl_xfer_unit`

## Requirements
- R1: After reset the pointer and latch are zero, busy is low, and neither memory strobe nor the file write enable is active.
- R2: Word 1010_00tx (bits 15:10 = 101000, t = bit 9) drives file_we high in its issue cycle, with file_wdata set to the latch low byte when t = 0 or the high byte when t = 1, and file_addr set to bits 7:0. Busy stays low, and the latch and pointer are unchanged.
- R3: Word 1010_01tx loads file_rdata into the latch half chosen by t at the issue edge. The other half and the pointer are unchanged.
- R4: Word 1010_10ti (table read) writes the selected pre-read latch byte to the file in its issue cycle. It then asserts mem_rd with mem_addr equal to the pointer until mem_ready, and loads the latch with mem_rdata. With ready immediately high it takes 2 cycles; each cycle of waiting adds one.
- R5: For the two transfer forms, i = bit 8 set to 1 makes the pointer advance by one (wrapping at 16 bits) when the transfer completes. With i = 0 the pointer is unchanged.
- R6: Word 1010_11ti (table write) merges file_rdata into latch half t at issue. It then asserts mem_wr with mem_wdata equal to the merged latch and mem_addr equal to the pointer, holding both steady until mem_ready. With ready immediately high it takes 2 cycles.
- R7: Abort during an unacknowledged write ends it on the next edge with no increment; the latch keeps its merged value.
- R8: A table read whose bits 7:0 equal the program-counter-low address (parameter, default 02h) takes one extra busy cycle, 3 in total.
- R9: While busy, a valid instruction is ignored: no file write, no latch change.
- R10: Words whose bits 15:12 are not 1010, or whose bits 11:10 do not select a table form, change nothing and produce no file write and no memory strobe.
- R11: ptr_set loads ptr_val into the pointer on the next edge and takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word present |
| ins_word | input | 16 | Instruction word |
| file_rdata | input | 8 | Byte read from the addressed file register |
| file_wdata | output | 8 | Byte to write to the file register |
| file_we | output | 1 | File register write enable |
| file_addr | output | 8 | File register address taken from the word |
| ptr_set | input | 1 | Load the pointer |
| ptr_val | input | PTR_W | Pointer load value |
| mem_addr | output | PTR_W | Program memory address |
| mem_rd | output | 1 | Program memory read strobe |
| mem_wr | output | 1 | Program memory write strobe |
| mem_wdata | output | 16 | Program memory write word |
| mem_rdata | input | 16 | Program memory read word |
| mem_ready | input | 1 | Memory completes the current access |
| abort | input | 1 | Ends a pending write |
| busy | output | 1 | Transfer in progress |
| tbl_ptr | output | PTR_W | Current table pointer |
| tbl_lat | output | 16 | Current table latch |

## Verification
The bench walks every combination of byte select and increment bit for both transfer forms. It does this at pointers of zero, all ones, and two mid values, so the wrap of the pointer and the half merge can be told apart from a plain copy. Memory returns a byte-swapped, scrambled copy of its address. A latch reload therefore cannot be confused with a stale latch or a wrong address. Reads run with ready at zero and two cycles of latency, both to and away from the program-counter-low address, so the cycle counts separate the wait stall from the extra cycle. One long write is aborted while another instruction is presented, and the ignored word, the missing increment and the missing memory write are each seen at the ports.

// File: rtl/tblu_pkg.sv
package tblu_pkg;
  localparam int BYTE_W  = 8;
  localparam int LAT_W   = 2 * BYTE_W;
  localparam int INSTR_W = 16;
  localparam int FADDR_W = 8;

  typedef enum logic [2:0] {K_NONE, K_LRD, K_LWT, K_TRD, K_TWT} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_RD, S_PCL, S_WR} seq_e;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [LAT_W-1:0] l, input logic hi);
    return hi ? l[LAT_W-1:BYTE_W] : l[BYTE_W-1:0];
  endfunction

  function automatic logic [LAT_W-1:0] merge_byte(input logic [LAT_W-1:0] l, input logic hi,
                                                  input logic [BYTE_W-1:0] b);
    return hi ? {b, l[BYTE_W-1:0]} : {l[LAT_W-1:BYTE_W], b};
  endfunction
endpackage

// File: rtl/tblu_decode.sv
module tblu_decode
  import tblu_pkg::*;
#(
  parameter logic [FADDR_W-1:0] PCL_ADDR = 8'h02
) (
  input  logic [INSTR_W-1:0] word,
  output kind_e              kind,
  output logic               hi,
  output logic               inc,
  output logic               to_pcl,
  output logic [FADDR_W-1:0] faddr
);
  always_comb begin
    kind = K_NONE;
    if (word[15:12] == 4'b1010) begin
      case (word[11:10])
        2'b00:   kind = K_LRD;
        2'b01:   kind = K_LWT;
        2'b10:   kind = K_TRD;
        default: kind = K_TWT;
      endcase
    end
  end

  assign hi     = word[9];
  assign inc    = word[8];
  assign faddr  = word[FADDR_W-1:0];
  assign to_pcl = (word[FADDR_W-1:0] == PCL_ADDR);
endmodule

// File: rtl/tblu_seq.sv
module tblu_seq
  import tblu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  kind_e kind,
  input  logic  inc_in,
  input  logic  pcl_in,
  input  logic  mem_ready,
  input  logic  abort,
  output logic  busy,
  output logic  mem_rd,
  output logic  mem_wr,
  output logic  rd_fin,
  output logic  wr_fin,
  output logic  step_ptr,
  output logic  file_we,
  output logic  byte_wr
);
  seq_e state, state_n;
  logic inc_q, pcl_q;

  assign busy    = (state != S_IDLE);
  assign mem_rd  = (state == S_RD);
  assign mem_wr  = (state == S_WR);
  assign rd_fin  = mem_rd && mem_ready;
  assign wr_fin  = mem_wr && mem_ready;
  assign step_ptr = (rd_fin || wr_fin) && inc_q;
  assign file_we = accept && (kind == K_LRD || kind == K_TRD);
  assign byte_wr = accept && (kind == K_LWT || kind == K_TWT);

  always_comb begin
    state_n = state;
    case (state)
      S_IDLE: begin
        if (accept && kind == K_TRD) state_n = S_RD;
        else if (accept && kind == K_TWT) state_n = S_WR;
      end
      S_RD:  if (mem_ready) state_n = pcl_q ? S_PCL : S_IDLE;
      S_PCL: state_n = S_IDLE;
      S_WR:  if (mem_ready || abort) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      inc_q <= 1'b0;
      pcl_q <= 1'b0;
    end else begin
      state <= state_n;
      if (accept) begin
        inc_q <= inc_in;
        pcl_q <= pcl_in && (kind == K_TRD);
      end
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R8
  pcl_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fin && pcl_q) |=> (busy && !mem_rd && !mem_wr));
  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready && !abort) |=> mem_wr);
  // R7
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && abort) |=> !busy);
endmodule

// File: rtl/tblu_ptr.sv
module tblu_ptr #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [PTR_W-1:0] set_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (set)  ptr <= set_val;
    else if (step) ptr <= ptr + ONE;
  end

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !step) |=> $stable(ptr));
  // R11
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> (ptr == $past(set_val)));
endmodule

// File: rtl/tblu_latch.sv
module tblu_latch
  import tblu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_wr,
  input  logic              hi,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              full_wr,
  input  logic [LAT_W-1:0]  full_in,
  output logic [LAT_W-1:0]  lat
);
  always_ff @(posedge clk) begin
    if (!rst_n)       lat <= '0;
    else if (full_wr) lat <= full_in;
    else if (byte_wr) lat <= merge_byte(lat, hi, byte_in);
  end

  // R3
  lat_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !full_wr && hi) |=> (lat[BYTE_W-1:0] == $past(lat[BYTE_W-1:0])));
  // R3
  lat_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !full_wr && !hi) |=> (lat[LAT_W-1:BYTE_W] == $past(lat[LAT_W-1:BYTE_W])));
endmodule

// File: rtl/tbl_xfer_unit.sv
module tbl_xfer_unit
  import tblu_pkg::*;
#(
  parameter int                 PTR_W    = 16,
  parameter logic [FADDR_W-1:0] PCL_ADDR = 8'h02
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_valid,
  input  logic [INSTR_W-1:0] ins_word,
  input  logic [BYTE_W-1:0]  file_rdata,
  output logic [BYTE_W-1:0]  file_wdata,
  output logic               file_we,
  output logic [FADDR_W-1:0] file_addr,
  input  logic               ptr_set,
  input  logic [PTR_W-1:0]   ptr_val,
  output logic [PTR_W-1:0]   mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [LAT_W-1:0]   mem_wdata,
  input  logic [LAT_W-1:0]   mem_rdata,
  input  logic               mem_ready,
  input  logic               abort,
  output logic               busy,
  output logic [PTR_W-1:0]   tbl_ptr,
  output logic [LAT_W-1:0]   tbl_lat
);
  kind_e kind;
  logic  hi, inc, to_pcl, accept;
  logic  rd_fin, wr_fin, step_ptr, byte_wr;

  tblu_decode #(.PCL_ADDR(PCL_ADDR)) u_dec (
    .word(ins_word), .kind(kind), .hi(hi), .inc(inc), .to_pcl(to_pcl), .faddr(file_addr)
  );

  assign accept = ins_valid && !busy;

  tblu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .kind(kind), .inc_in(inc), .pcl_in(to_pcl),
    .mem_ready(mem_ready), .abort(abort), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .rd_fin(rd_fin), .wr_fin(wr_fin), .step_ptr(step_ptr), .file_we(file_we), .byte_wr(byte_wr)
  );

  tblu_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .set(ptr_set), .set_val(ptr_val), .step(step_ptr), .ptr(tbl_ptr)
  );

  tblu_latch u_lat (
    .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .hi(hi), .byte_in(file_rdata),
    .full_wr(rd_fin), .full_in(mem_rdata), .lat(tbl_lat)
  );

  assign file_wdata = pick_byte(tbl_lat, hi);
  assign mem_addr   = tbl_ptr;
  assign mem_wdata  = tbl_lat;

  // R6
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready && !abort && !ptr_set) |=> ($stable(mem_wdata) && $stable(mem_addr)));
  // R9
  busy_no_fwe_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !file_we);
  // R4
  rd_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fin |=> (tbl_lat == $past(mem_rdata)));
endmodule

// File: tb/sim_tbl_xfer_unit.sv
module sim_tbl_xfer_unit;
  localparam int CLK_NS = 10;
  localparam logic [7:0] PCL = 8'h02;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic [15:0] ins_word = '0;
  logic [7:0]  file_rdata = '0, file_wdata, file_addr;
  logic file_we, ptr_set = 1'b0, mem_rd, mem_wr, mem_ready, abort = 1'b0, busy;
  logic [15:0] ptr_val = '0, mem_addr, mem_wdata, mem_rdata, tbl_ptr, tbl_lat;

  tbl_xfer_unit #(.PTR_W(16), .PCL_ADDR(PCL)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
    .file_rdata(file_rdata), .file_wdata(file_wdata), .file_we(file_we), .file_addr(file_addr),
    .ptr_set(ptr_set), .ptr_val(ptr_val), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .abort(abort),
    .busy(busy), .tbl_ptr(tbl_ptr), .tbl_lat(tbl_lat)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0;
  int lat_cfg = 0, wcnt = 0, wr_cnt = 0;
  logic [15:0] wr_addr = '0, wr_data = '0;

  function automatic logic [15:0] memfn(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction
  function automatic logic [7:0] sel8(input logic [15:0] l, input int t);
    return 8'((l >> (8 * t)) & 16'h00FF);
  endfunction
  function automatic logic [15:0] put8(input logic [15:0] l, input int t, input logic [7:0] b);
    logic [15:0] m = 16'h00FF << (8 * t);
    return (l & ~m) | (16'(b) << (8 * t));
  endfunction
  function automatic logic [15:0] word(input int k, input int t, input int i, input logic [7:0] f);
    return {4'b1010, 2'(k), 1'(t), 1'(i), f};
  endfunction
  function automatic logic [15:0] plist(input int n);
    case (n)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h1234;
      default: return 16'h80FE;
    endcase
  endfunction

  assign mem_rdata = memfn(mem_addr);
  assign mem_ready = (mem_rd || mem_wr) && (wcnt >= lat_cfg);

  always @(posedge clk) begin
    if ((mem_rd || mem_wr) && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_wr && mem_ready) begin
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= mem_addr;
      wr_data <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  logic cap_we;
  logic [7:0] cap_data, cap_addr;
  int cyc;

  task automatic issue(input logic [15:0] w);
    ins_word = w; ins_valid = 1'b1;
    #1;
    cap_we = file_we; cap_data = file_wdata; cap_addr = file_addr;
    @(negedge clk);
    ins_valid = 1'b0;
    cyc = 1;
    while (busy) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic set_ptr(input logic [15:0] v);
    ptr_set = 1'b1; ptr_val = v;
    @(negedge clk);
    ptr_set = 1'b0;
  endtask

  task automatic load_latch(input logic [15:0] v);
    file_rdata = v[7:0];  issue(word(1, 0, 0, 8'h20));
    file_rdata = v[15:8]; issue(word(1, 1, 0, 8'h20));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] p, L, e;
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ptr", 32'(tbl_ptr), 0);
    chk("R1 lat", 32'(tbl_lat), 0);
    chk("R1 idle", 32'({busy, mem_rd, mem_wr, file_we}), 0);
    @(negedge clk);

    // R11 pointer load
    set_ptr(16'hBEEF);
    chk("R11 ptr_set", 32'(tbl_ptr), 32'h0000BEEF);

    // R2 / R3 latch-only forms
    for (int pi = 0; pi < 4; pi++) begin
      p = plist(pi);
      set_ptr(p);
      for (int t = 0; t < 2; t++) begin
        L = 16'hC3A5 ^ p;
        load_latch(L);
        file_rdata = 8'(p[7:0] + 8'h5B + 8'(t));
        issue(word(1, t, pi & 1, 8'h31));
        e = put8(L, t, file_rdata);
        chk("R3 lwt half", 32'(tbl_lat), 32'(e));
        chk("R3 lwt ptr", 32'(tbl_ptr), 32'(p));
        chk("R3 lwt cycles", 32'(cyc), 1);
        issue(word(0, t, pi & 1, 8'h47));
        chk("R2 lrd data", 32'(cap_data), 32'(sel8(e, t)));
        chk("R2 lrd we/addr", 32'({cap_we, cap_addr}), 32'({1'b1, 8'h47}));
        chk("R2 lrd cycles", 32'(cyc), 1);
        chk("R2 lrd keep", 32'({tbl_lat, tbl_ptr}), 32'({e, p}));
      end
    end

    // R4 / R5 / R8 table reads
    for (int pi = 0; pi < 4; pi++)
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < 2; i++)
          for (int lt = 0; lt < 2; lt++)
            for (int pc = 0; pc < 2; pc++) begin
              p = plist(pi);
              set_ptr(p);
              L = 16'h7E81 + 16'(pi * 16 + t * 4 + i);
              load_latch(L);
              lat_cfg = lt * 2;
              issue(word(2, t, i, pc ? PCL : 8'h10));
              lat_cfg = 0;
              chk("R4 trd file byte", 32'({cap_we, cap_data}), 32'({1'b1, sel8(L, t)}));
              chk("R4 trd reload", 32'(tbl_lat), 32'(memfn(p)));
              chk("R5 trd ptr", 32'(tbl_ptr), 32'(16'(p + 16'(i))));
              if (pc) chk("R8 pcl cycles", 32'(cyc), 32'(3 + lt * 2));
              else    chk("R4 trd cycles", 32'(cyc), 32'(2 + lt * 2));
            end

    // R6 / R5 table writes
    for (int pi = 0; pi < 4; pi++)
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < 2; i++)
          for (int lt = 0; lt < 2; lt++) begin
            p = plist(pi);
            set_ptr(p);
            L = 16'h9A0F ^ 16'(pi * 257);
            load_latch(L);
            file_rdata = 8'(8'h3C + 8'(t * 17 + i * 5));
            lat_cfg = lt * 3;
            w0 = wr_cnt;
            issue(word(3, t, i, 8'h55));
            lat_cfg = 0;
            e = put8(L, t, file_rdata);
            chk("R6 twt count", 32'(wr_cnt - w0), 1);
            chk("R6 twt data", 32'(wr_data), 32'(e));
            chk("R6 twt addr", 32'(wr_addr), 32'(p));
            chk("R6 twt cycles", 32'(cyc), 32'(2 + lt * 3));
            chk("R5 twt ptr", 32'(tbl_ptr), 32'(16'(p + 16'(i))));
            chk("R6 twt latch", 32'(tbl_lat), 32'(e));
          end

    // R7 abort and R9 busy-ignore
    set_ptr(16'h4000);
    load_latch(16'h1111);
    lat_cfg = 50;
    w0 = wr_cnt;
    file_rdata = 8'hEE;
    ins_word = word(3, 1, 1, 8'h60); ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 write pending", 32'({busy, mem_wr}), 32'(2'b11));
    file_rdata = 8'h77;
    ins_word = word(0, 0, 0, 8'h61); ins_valid = 1'b1;
    #1;
    chk("R9 no file write while busy", 32'(file_we), 0);
    @(negedge clk);
    ins_word = word(1, 0, 0, 8'h61);
    @(negedge clk);
    ins_valid = 1'b0;
    chk("R9 latch untouched while busy", 32'(tbl_lat), 32'h0000EE11);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    lat_cfg = 0;
    chk("R7 abort ends", 32'(busy), 0);
    chk("R7 no write", 32'(wr_cnt - w0), 0);
    chk("R7 no increment", 32'(tbl_ptr), 32'h00004000);
    chk("R7 latch kept", 32'(tbl_lat), 32'h0000EE11);

    // R10 foreign words
    for (int k = 0; k < 6; k++) begin
      logic [15:0] fw;
      case (k)
        0: fw = 16'h0000;
        1: fw = 16'hB000;
        2: fw = 16'h2A10;
        3: fw = 16'hFFFF;
        4: fw = 16'h8F02;
        default: fw = 16'h6C33;
      endcase
      ins_word = fw; ins_valid = 1'b1;
      #1;
      chk("R10 no file write", 32'(file_we), 0);
      @(negedge clk);
      ins_valid = 1'b0;
      chk("R10 no activity", 32'({busy, mem_rd, mem_wr}), 0);
      chk("R10 state kept", 32'({tbl_lat, tbl_ptr}), 32'({16'hEE11, 16'h4000}));
    end

    // R11 priority over a completing increment
    load_latch(16'h0000);
    ins_word = word(2, 0, 1, 8'h10); ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    ptr_set = 1'b1; ptr_val = 16'h0A0A;
    @(negedge clk);
    ptr_set = 1'b0;
    chk("R11 set beats increment", 32'(tbl_ptr), 32'h00000A0A);
    chk("R4 read at old pointer", 32'(tbl_lat), 32'(memfn(16'h4000)));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule